// File: doc/BRIEF.md
# Two-Stage Escalating Watchdog

This block watches a free-running 64-bit platform time value and escalates in two steps when software stops servicing it. Software holds two absolute 64-bit thresholds, a warning threshold and a reset threshold. When the time value reaches the warning threshold, the block raises an interrupt and arms the reset stage. If the time then reaches the reset threshold while that stage is still armed, the block raises a system reset request. The request stays asserted until the block itself is reset.

Software services the watchdog by rewriting the warning threshold, normally to a point in the future. Any write to either half of that register clears the interrupt and disarms the reset stage. Both thresholds are written and read as 32-bit halves on a simple word-indexed port. After reset both thresholds hold all ones, so the watchdog stays idle. To change a threshold without a false expiry between the two half writes, software first writes all ones to the low half, then writes the new high half, then the new low half. The time counter, the reset mechanism and the routing of the interrupt belong to the surrounding chip.

Top module: `wdt2_top`

## Requirements
- R1: While `rst` is high at a clock edge, both thresholds become all ones and `irq_o` and `rst_req_o` become 0 after that edge. At all-ones thresholds, nothing fires for any time value below all ones.
- R2: Word index 0 is the warning threshold bits 31:0, 1 is the warning threshold bits 63:32, 2 is the reset threshold bits 31:0 and 3 is the reset threshold bits 63:32. A write changes only the addressed half. `rd_data` shows the half selected by `rd_word` without delay.
- R3: When `time_val` >= the warning threshold (64-bit unsigned) at a clock edge with no service write, `irq_o` is 1 after that edge.
- R4: Once raised, `irq_o` stays 1 even if the time value falls below the threshold again. Only a service write or reset clears it.
- R5: A service write is a write to word 0 or 1. It forces `irq_o` to 0 after that edge and wins over a warning hit in the same cycle. Writes to words 2 and 3 do not clear `irq_o`.
- R6: When `irq_o` is 1, `time_val` >= the reset threshold and there is no service write at a clock edge, `rst_req_o` is 1 after that edge.
- R7: While `irq_o` is 0, reaching the reset threshold does not raise `rst_req_o`.
- R8: Once raised, `rst_req_o` stays 1 through service writes and threshold changes until `rst`.
- R9: The three-write sequence (all ones to the low half, new high half, new low half) on the warning threshold raises no interrupt while the time value is below the new threshold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| time_val | input | 64 | Platform time value |
| wr_en | input | 1 | Write strobe for one 32-bit half |
| wr_word | input | 2 | Word index of the write |
| wr_data | input | 32 | Write data |
| rd_word | input | 2 | Word index for the read |
| rd_data | output | 32 | Read data of the selected half |
| irq_o | output | 1 | Warning interrupt, also the armed state of the reset stage |
| rst_req_o | output | 1 | Sticky system reset request |

## Verification
The bench targets the exact-equality edge of the comparison. At threshold minus one nothing must fire, and at the threshold the output must fire; a strict greater-than comparison would miss that edge by one tick. It checks that a reset-stage hit with the stage unarmed is ignored, and that a service write in the same cycle as a warning hit or a reset-stage hit wins. A design that ordered these the other way would raise a reset request while software was servicing it. It also checks that the reset request survives a service write, that writes to the reset threshold do not clear the interrupt, and that the three-write update raises no interrupt part way through.

// File: rtl/wdt2_pkg.sv
package wdt2_pkg;

    localparam int TIME_W  = 64;
    localparam int BUS_W   = 32;
    localparam int HALVES  = TIME_W / BUS_W;
    localparam int WORD_W  = 2;

    typedef enum logic [WORD_W-1:0] {
        WD_WARN_LO  = 2'd0,
        WD_WARN_HI  = 2'd1,
        WD_RESET_LO = 2'd2,
        WD_RESET_HI = 2'd3
    } wd_word_e;

    typedef struct packed {
        logic             en;
        wd_word_e         word;
        logic [BUS_W-1:0] data;
    } wd_wr_t;

    typedef struct packed {
        logic warn_hit;
        logic reset_hit;
        logic service;
    } wd_evt_t;

    // A write to either half of the warning threshold services the watchdog
    function automatic logic is_service(input wd_wr_t w);
        return w.en && (w.word == WD_WARN_LO || w.word == WD_WARN_HI);
    endfunction

    function automatic logic is_warn_word(input wd_word_e w);
        return w == WD_WARN_LO || w == WD_WARN_HI;
    endfunction

endpackage

// File: rtl/wdt2_regs.sv
module wdt2_regs
    import wdt2_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  wd_wr_t            wr,
    input  wd_word_e          rd_word,
    output logic [BUS_W-1:0]  rd_data,
    output logic [TIME_W-1:0] warn_cmp,
    output logic [TIME_W-1:0] reset_cmp
);

    logic [TIME_W-1:0] warn_q;
    logic [TIME_W-1:0] reset_q;

    // Bit 0 of the word index picks the half, bit 1 picks the register
    generate
        for (genvar h = 0; h < HALVES; h++) begin : g_half
            always_ff @(posedge clk) begin
                if (rst) begin
                    warn_q[h*BUS_W +: BUS_W]  <= '1;
                    reset_q[h*BUS_W +: BUS_W] <= '1;
                end else if (wr.en && int'(wr.word[0]) == h) begin
                    if (is_warn_word(wr.word))
                        warn_q[h*BUS_W +: BUS_W]  <= wr.data;
                    else
                        reset_q[h*BUS_W +: BUS_W] <= wr.data;
                end
            end
        end
    endgenerate

    always_comb begin
        unique case (rd_word)
            WD_WARN_LO:  rd_data = warn_q[BUS_W-1:0];
            WD_WARN_HI:  rd_data = warn_q[TIME_W-1:BUS_W];
            WD_RESET_LO: rd_data = reset_q[BUS_W-1:0];
            default:     rd_data = reset_q[TIME_W-1:BUS_W];
        endcase
    end

    assign warn_cmp  = warn_q;
    assign reset_cmp = reset_q;

endmodule

// File: rtl/wdt2_ge_cmp.sv
module wdt2_ge_cmp #(
    parameter int WIDTH = 64,
    parameter int CHUNK = 16
) (
    input  logic [WIDTH-1:0] a,
    input  logic [WIDTH-1:0] b,
    output logic             a_ge_b
);

    localparam int NCH = WIDTH / CHUNK;

    logic [NCH-1:0] gt;
    logic [NCH-1:0] eq;
    logic [NCH:0]   ge_acc;

    assign ge_acc[0] = 1'b1;

    // Fold the chunks from least to most significant: a higher chunk decides
    // unless it is equal, in which case the lower result carries through
    generate
        for (genvar i = 0; i < NCH; i++) begin : g_chunk
            assign gt[i] = a[i*CHUNK +: CHUNK] > b[i*CHUNK +: CHUNK];
            assign eq[i] = a[i*CHUNK +: CHUNK] == b[i*CHUNK +: CHUNK];
            assign ge_acc[i+1] = gt[i] | (eq[i] & ge_acc[i]);
        end
    endgenerate

    assign a_ge_b = ge_acc[NCH];

endmodule

// File: rtl/wdt2_escalate.sv
module wdt2_escalate
    import wdt2_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  wd_evt_t evt,
    output logic    armed,
    output logic    tripped
);

    logic armed_q;
    logic tripped_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            armed_q   <= 1'b0;
            tripped_q <= 1'b0;
        end else begin
            if (evt.service)
                armed_q <= 1'b0;
            else if (evt.warn_hit)
                armed_q <= 1'b1;

            if (armed_q && evt.reset_hit && !evt.service)
                tripped_q <= 1'b1;
        end
    end

    assign armed   = armed_q;
    assign tripped = tripped_q;

endmodule

// File: rtl/wdt2_top.sv
module wdt2_top
    import wdt2_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [TIME_W-1:0] time_val,
    input  logic              wr_en,
    input  logic [WORD_W-1:0] wr_word,
    input  logic [BUS_W-1:0]  wr_data,
    input  logic [WORD_W-1:0] rd_word,
    output logic [BUS_W-1:0]  rd_data,
    output logic              irq_o,
    output logic              rst_req_o
);

    wd_wr_t            wr;
    wd_evt_t           evt;
    logic [TIME_W-1:0] warn_cmp;
    logic [TIME_W-1:0] reset_cmp;
    logic              warn_ge;
    logic              reset_ge;

    assign wr.en   = wr_en;
    assign wr.word = wd_word_e'(wr_word);
    assign wr.data = wr_data;

    wdt2_regs u_regs (
        .clk       (clk),
        .rst       (rst),
        .wr        (wr),
        .rd_word   (wd_word_e'(rd_word)),
        .rd_data   (rd_data),
        .warn_cmp  (warn_cmp),
        .reset_cmp (reset_cmp)
    );

    wdt2_ge_cmp #(.WIDTH(TIME_W), .CHUNK(16)) u_warn_cmp (
        .a      (time_val),
        .b      (warn_cmp),
        .a_ge_b (warn_ge)
    );

    wdt2_ge_cmp #(.WIDTH(TIME_W), .CHUNK(16)) u_reset_cmp (
        .a      (time_val),
        .b      (reset_cmp),
        .a_ge_b (reset_ge)
    );

    assign evt.warn_hit  = warn_ge;
    assign evt.reset_hit = reset_ge;
    assign evt.service   = is_service(wr);

    wdt2_escalate u_esc (
        .clk     (clk),
        .rst     (rst),
        .evt     (evt),
        .armed   (irq_o),
        .tripped (rst_req_o)
    );

endmodule

// File: rtl/wdt2_chk.sv
module wdt2_chk
    import wdt2_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic [TIME_W-1:0] time_val,
    input logic              wr_en,
    input logic [WORD_W-1:0] wr_word,
    input logic [TIME_W-1:0] warn_cmp,
    input logic [TIME_W-1:0] reset_cmp,
    input logic              irq_o,
    input logic              rst_req_o
);

    logic svc;
    assign svc = wr_en && !wr_word[1];

    // R1
    reset_clears_chk: assert property (@(posedge clk)
        rst |=> (!irq_o && !rst_req_o));

    // R3
    warn_fires_chk: assert property (@(posedge clk) disable iff (rst)
        (time_val >= warn_cmp && !svc) |=> irq_o);

    // R5
    service_clears_chk: assert property (@(posedge clk) disable iff (rst)
        svc |=> !irq_o);

    // R6
    reset_fires_chk: assert property (@(posedge clk) disable iff (rst)
        (irq_o && time_val >= reset_cmp && !svc) |=> rst_req_o);

    // R7
    unarmed_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        (!irq_o && !rst_req_o) |=> !rst_req_o);

    // R8
    req_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        rst_req_o |=> rst_req_o);

endmodule

bind wdt2_top wdt2_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .time_val  (time_val),
    .wr_en     (wr_en),
    .wr_word   (wr_word),
    .warn_cmp  (warn_cmp),
    .reset_cmp (reset_cmp),
    .irq_o     (irq_o),
    .rst_req_o (rst_req_o)
);

// File: tb/wdt2_top_test.sv
module wdt2_top_test;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [63:0] time_val = '0;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_word = '0;
    logic [31:0] wr_data = '0;
    logic [1:0]  rd_word = '0;
    logic [31:0] rd_data;
    logic        irq_o;
    logic        rst_req_o;

    int total = 0;
    int bad = 0;
    int cyc = 0;
    string cur_req = "R1";

    logic [63:0] m_warn = '1;
    logic [63:0] m_reset = '1;
    logic        m_irq = 1'b0;
    logic        m_req = 1'b0;

    always #2 clk = ~clk;

    wdt2_top uut (
        .clk(clk), .rst(rst), .time_val(time_val),
        .wr_en(wr_en), .wr_word(wr_word), .wr_data(wr_data),
        .rd_word(rd_word), .rd_data(rd_data),
        .irq_o(irq_o), .rst_req_o(rst_req_o)
    );

    function automatic logic [31:0] model_read(input logic [1:0] w);
        case (w)
            2'd0: return m_warn[31:0];
            2'd1: return m_warn[63:32];
            2'd2: return m_reset[31:0];
            default: return m_reset[63:32];
        endcase
    endfunction

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s cycle %0d: actual=%0h expected=%0h", req, cyc, act, exp);
        end
    endtask

    // One cycle: check outputs at the falling edge, then apply new inputs and
    // advance the model to the state expected after the next rising edge.
    task automatic step(input logic r, input logic we, input logic [1:0] w,
                        input logic [31:0] d, input logic [63:0] t);
        logic h1, h2, svc;
        @(negedge clk);
        cyc++;
        chk({cur_req, " irq"}, {63'd0, irq_o}, {63'd0, m_irq});
        chk({cur_req, " rst_req"}, {63'd0, rst_req_o}, {63'd0, m_req});
        chk("R2 readback", {32'd0, rd_data}, {32'd0, model_read(rd_word)});
        rst = r; wr_en = we; wr_word = w; wr_data = d; time_val = t;
        rd_word = 2'($urandom_range(0, 3));
        h1  = t >= m_warn;
        h2  = t >= m_reset;
        svc = we && !w[1];
        if (r) begin
            m_warn = '1; m_reset = '1; m_irq = 1'b0; m_req = 1'b0;
        end else begin
            m_req = m_req | (m_irq & h2 & !svc);
            m_irq = svc ? 1'b0 : (m_irq | h1);
            if (we) begin
                case (w)
                    2'd0: m_warn[31:0]   = d;
                    2'd1: m_warn[63:32]  = d;
                    2'd2: m_reset[31:0]  = d;
                    default: m_reset[63:32] = d;
                endcase
            end
        end
    endtask

    task automatic idle(input logic [63:0] t, input int n);
        for (int i = 0; i < n; i++) step(1'b0, 1'b0, 2'd0, 32'd0, t);
    endtask

    // Three-write update of one threshold: all ones low, new high, new low
    task automatic load(input logic is_reset, input logic [63:0] v, input logic [63:0] t);
        step(1'b0, 1'b1, {is_reset, 1'b0}, 32'hFFFF_FFFF, t);
        step(1'b0, 1'b1, {is_reset, 1'b1}, v[63:32], t);
        step(1'b0, 1'b1, {is_reset, 1'b0}, v[31:0], t);
    endtask

    initial begin
        void'($urandom(32'h00C0_FFEE));
        cur_req = "R1";
        step(1'b1, 1'b0, 2'd0, 32'd0, 64'd0);
        step(1'b0, 1'b0, 2'd0, 32'd0, 64'd0);
        idle(64'hFFFF_FFFF_FFFF_FFFE, 4);
        for (int w = 0; w < 4; w++) begin
            @(negedge clk);
            rd_word = 2'(w);
            #0.5;
            chk("R1 reset value", {32'd0, rd_data}, 64'h0000_0000_FFFF_FFFF);
        end

        cur_req = "R7";
        load(1'b1, 64'd100, 64'd10);
        idle(64'd500, 6);

        cur_req = "R2";
        step(1'b0, 1'b1, 2'd3, 32'h0000_0001, 64'd500);
        step(1'b0, 1'b1, 2'd2, 32'h0000_0BB8, 64'd500);
        step(1'b0, 1'b1, 2'd3, 32'h0000_0000, 64'd500);
        idle(64'd500, 4);

        cur_req = "R9";
        load(1'b0, 64'd2000, 64'd1000);
        idle(64'd1000, 3);

        cur_req = "R3";
        idle(64'd1999, 3);
        idle(64'd2000, 3);

        cur_req = "R4";
        idle(64'd10, 4);

        cur_req = "R5";
        step(1'b0, 1'b1, 2'd2, 32'd3000, 64'd10);
        idle(64'd10, 2);
        step(1'b0, 1'b1, 2'd1, 32'd0, 64'd2500);
        idle(64'd2500, 2);
        load(1'b0, 64'd10000, 64'd2500);

        cur_req = "R7";
        idle(64'd3000, 4);

        cur_req = "R6";
        idle(64'd10000, 4);

        cur_req = "R8";
        load(1'b0, 64'd90000, 64'd10000);
        idle(64'd10000, 3);
        load(1'b1, 64'hFFFF_FFFF_FFFF_FF00, 64'd10000);
        idle(64'd10000, 2);

        cur_req = "R1";
        step(1'b1, 1'b0, 2'd0, 32'd0, 64'd10000);
        idle(64'd10000, 3);

        cur_req = "R6";
        begin
            logic [63:0] t = 64'd0;
            for (int i = 0; i < 4000; i++) begin
                logic r, we;
                logic [1:0] w;
                logic [31:0] d;
                t = t + 64'($urandom_range(0, 20));
                r = ($urandom_range(0, 599) == 0);
                we = ($urandom_range(0, 9) == 0);
                w = 2'($urandom_range(0, 3));
                d = w[0] ? 32'd0 : 32'(t) + 32'($urandom_range(0, 300));
                step(r, we, w, d, t);
            end
        end
        step(1'b0, 1'b0, 2'd0, 32'd0, time_val);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        bad++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule